// File: doc/BRIEF.md
# Panel Power Pin Sequencer

This block plays back short pin programs that bring a display panel's supply and reset lines up and down in the right order. Each program is a list of steps. Each step names an output pin, the level to put on it, and how many milliseconds to wait before the next step. Three program slots are held: one for after the link enters its low-power idle state, one for after the panel's start-up commands, and one for after its shut-down commands. Each slot has its own start strobe and its own done bit.

The steps are written into a small table through a write port. A step holds a pin index, a level, a delay and a valid flag. A program ends at its first invalid step, or after the last table row. A slot whose first step is invalid is an empty program: it finishes with no pin activity. The millisecond time base comes from a divider. The divider count `div_val` gives the number of clock cycles per millisecond, minus one.

The controller has four named states. **IDLE** waits for a start strobe. **FETCH** reads the current step; on a valid step it drives the pin and loads the delay. **HOLD** waits out the delay. **FINISH** raises done for one cycle. The transitions are:
- IDLE→FETCH on any start strobe (*launch*).
- FETCH→HOLD on a valid step with a nonzero delay (*arm*).
- FETCH→FETCH on a zero-delay step that is not the last row (*skip*).
- FETCH→FINISH on an invalid step, or on a zero-delay last row (*end*).
- HOLD→FETCH when the delay expires on a row that is not the last (*next*).
- HOLD→FINISH when the delay expires on the last row (*last*).
- FINISH→IDLE (*retire*).

Top module: `pnl_pwr_seq`

## Requirements
- R1: After reset, all pin outputs are 0, busy is 0, done is 0, and every table row is invalid.
- R2: A valid step drives its pin to its level on the first cycle of the step. The new level is visible one cycle after the step begins. Steps run in table order, starting from row 0.
- R3: A step with delay d ≥ 1 lasts 1 + d·(div_val+1) cycles. The next step begins right after that.
- R4: A step with delay 0 lasts one cycle. The next step begins on the following cycle.
- R5: A program ends at its first invalid row, which costs one cycle, or after row MAX_STEPS-1. The done bit of the started slot (bit 0, 1 or 2) is high for exactly one cycle. That cycle comes S cycles after the cycle in which the first step begins, where S is the sum of the step lengths, plus one if an invalid row stopped the program.
- R6: A slot whose row 0 is invalid completes one cycle after its first step begins, with no change on any pin.
- R7: Pins not named by the running step keep their level. A step whose pin index is NUM_PINS or larger changes no pin, but its delay still applies.
- R8: A start strobe that arrives while busy is high is ignored. The running program and its timing are unaffected, and the ignored slot raises no done.
- R9: If several start strobes arrive together while idle, the lowest-numbered slot runs and the others are dropped.
- R10: busy goes high the cycle after an accepted start, stays high through the done cycle, and is low on the cycle after done.
- R11: Each of the three slots plays back only its own table rows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 3 | Per-slot start strobes (bit 0 = after low-power idle, 1 = after start-up commands, 2 = after shut-down commands) |
| div_val | input | DIV_W | Clock cycles per millisecond, minus one |
| tbl_we | input | 1 | Table write enable |
| tbl_slot | input | 2 | Slot of the row being written |
| tbl_idx | input | IDX_W | Row number within the slot |
| tbl_pin | input | PIN_W | Pin index of the step |
| tbl_level | input | 1 | Level to drive |
| tbl_delay | input | DLY_W | Delay in milliseconds |
| tbl_valid | input | 1 | Row holds a step |
| gpio_out | output | NUM_PINS | Pin levels |
| busy | output | 1 | A program is running |
| done | output | 3 | One-cycle completion pulse for each slot |

## Verification
The playback path is tried in four ways:
- Zero-delay chains separate the one-cycle step from the timed step.
- Delays under several divider settings show that time scales with both the delay and the divider.
- Short, full-length and empty programs set the invalid-row stop apart from the last-row stop.
- Out-of-range pin indices show that the delay still runs while no pin moves.

Start strobes given in the middle of a program, or several at once, separate the ignore rule from the priority rule. Every one of these cases is compared cycle by cycle with a model of expected pin, busy and done values.

// File: rtl/pps_pkg.sv
package pps_pkg;
    localparam int SLOTS = 3;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_HOLD,
        ST_FINISH
    } seq_state_t;
endpackage

// File: rtl/pps_step_table.sv
module pps_step_table #(
    parameter int MAX_STEPS = 4,
    parameter int PIN_W     = 8,
    parameter int DLY_W     = 8,
    localparam int IDX_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       w_slot,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [PIN_W-1:0] w_pin,
    input  logic             w_lvl,
    input  logic [DLY_W-1:0] w_dly,
    input  logic             w_vld,
    input  logic [1:0]       r_slot,
    input  logic [IDX_W-1:0] r_idx,
    output logic [PIN_W-1:0] r_pin,
    output logic             r_lvl,
    output logic [DLY_W-1:0] r_dly,
    output logic             r_vld
);
    import pps_pkg::*;

    logic [PIN_W-1:0] pin_q [SLOTS][MAX_STEPS];
    logic             lvl_q [SLOTS][MAX_STEPS];
    logic [DLY_W-1:0] dly_q [SLOTS][MAX_STEPS];
    logic             vld_q [SLOTS][MAX_STEPS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < SLOTS; s++) begin
                for (int i = 0; i < MAX_STEPS; i++) begin
                    pin_q[s][i] <= '0;
                    lvl_q[s][i] <= 1'b0;
                    dly_q[s][i] <= '0;
                    vld_q[s][i] <= 1'b0;
                end
            end
        end else if (we && (int'(w_slot) < SLOTS) && (int'(w_idx) < MAX_STEPS)) begin
            pin_q[w_slot][w_idx] <= w_pin;
            lvl_q[w_slot][w_idx] <= w_lvl;
            dly_q[w_slot][w_idx] <= w_dly;
            vld_q[w_slot][w_idx] <= w_vld;
        end
    end

    always_comb begin
        r_pin = '0;
        r_lvl = 1'b0;
        r_dly = '0;
        r_vld = 1'b0;
        if ((int'(r_slot) < SLOTS) && (int'(r_idx) < MAX_STEPS)) begin
            r_pin = pin_q[r_slot][r_idx];
            r_lvl = lvl_q[r_slot][r_idx];
            r_dly = dly_q[r_slot][r_idx];
            r_vld = vld_q[r_slot][r_idx];
        end
    end
endmodule

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
    parameter int DIV_W = 8,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic [DIV_W-1:0] div_val,
    output logic             expire
);
    logic [DIV_W-1:0] div_cnt;
    logic [DLY_W-1:0] ms_left;
    logic             tick;

    assign tick   = (div_cnt == div_val);
    assign expire = tick && (ms_left == DLY_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
            ms_left <= '0;
        end else if (load) begin
            div_cnt <= '0;
            ms_left <= dly;
        end else if (ms_left != '0) begin
            if (tick) begin
                div_cnt <= '0;
                ms_left <= ms_left - DLY_W'(1);
            end else begin
                div_cnt <= div_cnt + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/pps_ctrl.sv
module pps_ctrl #(
    parameter int NUM_PINS  = 16,
    parameter int MAX_STEPS = 4,
    parameter int PIN_W     = 8,
    parameter int DLY_W     = 8,
    localparam int IDX_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1,
    localparam int GW       = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             start,
    input  logic [PIN_W-1:0]       r_pin,
    input  logic                   r_lvl,
    input  logic [DLY_W-1:0]       r_dly,
    input  logic                   r_vld,
    input  logic                   expire,
    output logic [1:0]             rd_slot,
    output logic [IDX_W-1:0]       rd_idx,
    output logic                   tmr_load,
    output logic [NUM_PINS-1:0]    gpio,
    output logic                   busy,
    output logic [2:0]             done
);
    import pps_pkg::*;

    seq_state_t       state_q, state_d;
    logic [1:0]       slot_q, pick;
    logic [IDX_W-1:0] idx_q;
    logic             last_row, pin_ok;

    assign last_row = (idx_q == IDX_W'(MAX_STEPS - 1));
    assign pin_ok   = (32'(r_pin) < NUM_PINS);

    always_comb begin
        pick = 2'd0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (start[s]) pick = 2'(s);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (|start) state_d = ST_FETCH;
            ST_FETCH: begin
                if (!r_vld)              state_d = ST_FINISH;
                else if (r_dly != '0)    state_d = ST_HOLD;
                else if (last_row)       state_d = ST_FINISH;
                else                     state_d = ST_FETCH;
            end
            ST_HOLD:   if (expire) state_d = last_row ? ST_FINISH : ST_FETCH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= 2'd0;
            idx_q  <= '0;
            gpio   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (|start) begin
                    slot_q <= pick;
                    idx_q  <= '0;
                end
                ST_FETCH: if (r_vld) begin
                    if (pin_ok) gpio[r_pin[GW-1:0]] <= r_lvl;
                    if (r_dly == '0) idx_q <= idx_q + IDX_W'(1);
                end
                ST_HOLD: if (expire) idx_q <= idx_q + IDX_W'(1);
                ST_FINISH: ;
                default: ;
            endcase
        end
    end

    assign rd_slot  = slot_q;
    assign rd_idx   = idx_q;
    assign tmr_load = (state_q == ST_FETCH) && r_vld && (r_dly != '0);
    assign busy     = (state_q != ST_IDLE);

    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            done[s] = (state_q == ST_FINISH) && (slot_q == 2'(s));
        end
    end
endmodule

// File: rtl/pnl_pwr_seq.sv
module pnl_pwr_seq #(
    parameter int NUM_PINS  = 16,
    parameter int MAX_STEPS = 4,
    parameter int PIN_W     = 8,
    parameter int DLY_W     = 8,
    parameter int DIV_W     = 8,
    localparam int IDX_W    = (MAX_STEPS > 1) ? $clog2(MAX_STEPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          start,
    input  logic [DIV_W-1:0]    div_val,
    input  logic                tbl_we,
    input  logic [1:0]          tbl_slot,
    input  logic [IDX_W-1:0]    tbl_idx,
    input  logic [PIN_W-1:0]    tbl_pin,
    input  logic                tbl_level,
    input  logic [DLY_W-1:0]    tbl_delay,
    input  logic                tbl_valid,
    output logic [NUM_PINS-1:0] gpio_out,
    output logic                busy,
    output logic [2:0]          done
);
    logic [1:0]       rd_slot;
    logic [IDX_W-1:0] rd_idx;
    logic [PIN_W-1:0] r_pin;
    logic             r_lvl, r_vld, tmr_load, expire;
    logic [DLY_W-1:0] r_dly;

    pps_step_table #(.MAX_STEPS(MAX_STEPS), .PIN_W(PIN_W), .DLY_W(DLY_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .we(tbl_we), .w_slot(tbl_slot), .w_idx(tbl_idx), .w_pin(tbl_pin),
        .w_lvl(tbl_level), .w_dly(tbl_delay), .w_vld(tbl_valid),
        .r_slot(rd_slot), .r_idx(rd_idx),
        .r_pin(r_pin), .r_lvl(r_lvl), .r_dly(r_dly), .r_vld(r_vld)
    );

    pps_ms_timer #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .dly(r_dly),
        .div_val(div_val), .expire(expire)
    );

    pps_ctrl #(.NUM_PINS(NUM_PINS), .MAX_STEPS(MAX_STEPS), .PIN_W(PIN_W), .DLY_W(DLY_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .r_pin(r_pin), .r_lvl(r_lvl), .r_dly(r_dly), .r_vld(r_vld),
        .expire(expire), .rd_slot(rd_slot), .rd_idx(rd_idx), .tmr_load(tmr_load),
        .gpio(gpio_out), .busy(busy), .done(done)
    );
endmodule

// File: rtl/pps_seq_chk.sv
module pps_seq_chk #(
    parameter int NUM_PINS = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          start,
    input logic [NUM_PINS-1:0] gpio_out,
    input logic                busy,
    input logic [2:0]          done
);
    // R5
    done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(done));

    // R5
    done_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |-> $past(busy));

    // R10
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|done) |=> !busy);

    // R10
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (|start)) |=> busy);

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(gpio_out));

    // R7
    single_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(gpio_out ^ $past(gpio_out)) <= 1);
endmodule

bind pnl_pwr_seq pps_seq_chk #(.NUM_PINS(NUM_PINS)) u_seq_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .gpio_out(gpio_out), .busy(busy), .done(done)
);

// File: tb/pnl_pwr_seq_test.sv
module pnl_pwr_seq_test;
    localparam int NP  = 16;
    localparam int MS  = 4;
    localparam int PW  = 8;
    localparam int DW  = 8;
    localparam int VW  = 8;
    localparam int IW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    start = '0;
    logic [VW-1:0] div_val = '0;
    logic          tbl_we = 1'b0;
    logic [1:0]    tbl_slot = '0;
    logic [IW-1:0] tbl_idx = '0;
    logic [PW-1:0] tbl_pin = '0;
    logic          tbl_level = 1'b0;
    logic [DW-1:0] tbl_delay = '0;
    logic          tbl_valid = 1'b0;
    logic [NP-1:0] gpio_out;
    logic          busy;
    logic [2:0]    done;

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    logic [NP-1:0] exp_g = '0;
    int m_n   [3];
    int m_pin [3][MS];
    int m_lvl [3][MS];
    int m_dly [3][MS];

    always #5 clk = ~clk;

    pnl_pwr_seq #(.NUM_PINS(NP), .MAX_STEPS(MS), .PIN_W(PW), .DLY_W(DW), .DIV_W(VW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .div_val(div_val),
        .tbl_we(tbl_we), .tbl_slot(tbl_slot), .tbl_idx(tbl_idx), .tbl_pin(tbl_pin),
        .tbl_level(tbl_level), .tbl_delay(tbl_delay), .tbl_valid(tbl_valid),
        .gpio_out(gpio_out), .busy(busy), .done(done)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 200000) begin
            miscompares++;
            $display("FAIL watchdog: run hung act=%0d exp<=200000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        vectors++;
        if (act !== expv) begin
            miscompares++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
        end
    endtask

    task automatic put_row(input int s, input int i, input int pin, input int lvl,
                           input int dly, input bit vld);
        @(negedge clk);
        tbl_we = 1'b1; tbl_slot = 2'(s); tbl_idx = IW'(i); tbl_pin = PW'(pin);
        tbl_level = lvl[0]; tbl_delay = DW'(dly); tbl_valid = vld;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic load_slot(input int s);
        for (int i = 0; i < m_n[s]; i++) put_row(s, i, m_pin[s][i], m_lvl[s][i], m_dly[s][i], 1'b1);
        if (m_n[s] < MS) put_row(s, m_n[s], 0, 0, 0, 1'b0);
    endtask

    // R3, R4, R5: expected program length in cycles
    function automatic int seq_len(input int s);
        int t = 0;
        for (int i = 0; i < m_n[s]; i++) t += 1 + m_dly[s][i] * (int'(div_val) + 1);
        if (m_n[s] < MS) t += 1;
        return t;
    endfunction

    // R2, R7: expected pins c cycles after the first step begins
    function automatic logic [NP-1:0] gp_at(input int s, input int c, input logic [NP-1:0] base);
        logic [NP-1:0] g = base;
        int t = 0;
        for (int i = 0; i < m_n[s]; i++) begin
            if (t + 1 <= c && m_pin[s][i] < NP) g[m_pin[s][i]] = m_lvl[s][i][0];
            t += 1 + m_dly[s][i] * (int'(div_val) + 1);
        end
        return g;
    endfunction

    task automatic run(input int s, input logic [2:0] trig, input logic [2:0] extra, input string tag);
        int S = seq_len(s);
        logic [NP-1:0] base = exp_g;
        @(negedge clk); start = trig;
        @(negedge clk); start = '0;
        for (int c = 0; c <= S + 1; c++) begin
            check({tag, "/R2 R7 gpio"}, 32'(gpio_out), 32'(gp_at(s, c, base)));
            check({tag, "/R10 busy"}, 32'(busy), 32'(c <= S));
            check({tag, "/R5 done"}, 32'(done), (c == S) ? (32'd1 << s) : 32'd0);
            start = (c == 0) ? extra : 3'b000;
            @(negedge clk);
        end
        start = '0;
        exp_g = gp_at(s, S, base);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 gpio", 32'(gpio_out), 0);
        check("R1 busy", 32'(busy), 0);
        check("R1 done", 32'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 done after release", 32'(done), 0);

        // R2: high / low / high on one pin, 3 ms each
        div_val = 8'd3;
        m_n[0] = 3;
        m_pin[0][0] = 11; m_lvl[0][0] = 1; m_dly[0][0] = 3;
        m_pin[0][1] = 11; m_lvl[0][1] = 0; m_dly[0][1] = 3;
        m_pin[0][2] = 11; m_lvl[0][2] = 1; m_dly[0][2] = 3;
        load_slot(0);
        run(0, 3'b001, 3'b000, "R2");

        // R4: zero-delay chain over the full table
        m_n[1] = 4;
        for (int i = 0; i < MS; i++) begin
            m_pin[1][i] = i + 2; m_lvl[1][i] = 1; m_dly[1][i] = 0;
        end
        load_slot(1);
        run(1, 3'b010, 3'b000, "R4");

        // R6: empty program
        m_n[2] = 0;
        load_slot(2);
        run(2, 3'b100, 3'b000, "R6");

        // R7: index beyond the pin range still waits
        div_val = 8'd1;
        m_n[2] = 2;
        m_pin[2][0] = 179; m_lvl[2][0] = 1; m_dly[2][0] = 2;
        m_pin[2][1] = 5;   m_lvl[2][1] = 1; m_dly[2][1] = 1;
        load_slot(2);
        run(2, 3'b100, 3'b000, "R7");

        // R8: strobes while running are dropped
        run(0, 3'b001, 3'b110, "R8");

        // R9: simultaneous strobes, lowest slot wins
        run(1, 3'b110, 3'b000, "R9");

        // R11: each slot uses its own rows
        run(2, 3'b100, 3'b000, "R11");
        run(0, 3'b001, 3'b000, "R11");

        // R3: random programs, delays and dividers
        for (int k = 0; k < 40; k++) begin
            int s = int'($urandom_range(0, 2));
            div_val = VW'($urandom_range(0, 3));
            m_n[s] = int'($urandom_range(0, MS));
            for (int i = 0; i < m_n[s]; i++) begin
                m_pin[s][i] = int'($urandom_range(0, NP + 3));
                m_lvl[s][i] = int'($urandom_range(0, 1));
                m_dly[s][i] = int'($urandom_range(0, 3));
            end
            load_slot(s);
            run(s, 3'(1 << s), ($urandom_range(0, 3) == 0) ? 3'b111 : 3'b000, "R3");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule